// File: doc/BRIEF.md
# Sign-Magnitude Adder-Subtractor

This block adds or subtracts two numbers held in sign-magnitude form. Each operand has a sign bit and an N-bit unsigned magnitude. A one-cycle `start` pulse, together with `op_sub` (0 = add, 1 = subtract), captures both operands. A small state machine then produces the result over one to three further clock edges. The result sign, result magnitude and an overflow flag are held on the outputs until the next accepted start. A one-cycle `done` pulse marks the end of each operation.

The magnitude datapath has a single N-bit adder with a carry out. When the effective operation is a true addition, the magnitudes are summed and the carry becomes the overflow flag. Otherwise the second magnitude is complemented and added with a carry-in of one. A carry out of one then means the first magnitude was not smaller, and the difference is final. A carry out of zero means the difference is negative. In that case the magnitude is bit-inverted in one cycle and incremented in the next, which gives its two's complement, and the sign is flipped.

States:
- `ST_IDLE` waits for `start`.
- `ST_ADD` performs the single add or complement-add.
- `ST_COMP` inverts the magnitude.
- `ST_INC` adds one and flips the sign.
- `ST_DONE` raises `done`.

Transitions:
- `ST_IDLE` to `ST_ADD` on `start`.
- `ST_ADD` to `ST_DONE` on a true add, or on a complement-add whose carry is 1.
- `ST_ADD` to `ST_COMP` on a complement-add whose carry is 0.
- `ST_COMP` to `ST_INC` always.
- `ST_INC` to `ST_DONE` always.
- `ST_DONE` to `ST_IDLE` always.

Top module: `sm_addsub_unit`

## Requirements
- R1: After reset, `res_sign`, `res_mag`, `ovf`, `done` and `busy` are all 0.
- R2: The effective operation is a true add when (`op_sub`=0 and the signs are equal) or (`op_sub`=1 and the signs differ). On this path, `res_mag` = (`a_mag`+`b_mag`) mod 2^N, `ovf` = the carry out of that sum, and `res_sign` = `a_sign`.
- R3: On the other path with `a_mag` >= `b_mag`, `res_mag` = `a_mag`-`b_mag`, `res_sign` = `a_sign` and `ovf` = 0.
- R4: On the other path with `a_mag` < `b_mag`, `res_mag` = `b_mag`-`a_mag`, `res_sign` = NOT `a_sign` and `ovf` = 0.
- R5: When the complement-add path gives a zero magnitude, `res_sign` is 0.
- R6: Count the edge that samples `start` as edge 0. `done` is high for exactly one cycle, following edge 1 on the true-add path and on the R3 path, and following edge 3 on the R4 path.
- R7: A `start` seen while `busy` is 1 is ignored. The result still reflects the accepted operation, and no extra `done` follows. In `ST_DONE` and in `ST_IDLE` without a start, the result outputs hold their values.
- R8: `busy` is 1 from the edge that samples `start` until the end of the `done` cycle, including the `done` cycle itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, sampled in ST_IDLE |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| a_sign | input | 1 | Sign of the first operand (1 = negative) |
| a_mag | input | N | Magnitude of the first operand |
| b_sign | input | 1 | Sign of the second operand |
| b_mag | input | N | Magnitude of the second operand |
| res_sign | output | 1 | Result sign |
| res_mag | output | N | Result magnitude |
| ovf | output | 1 | Magnitude overflow, set only on the true-add path |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
A wrong branch decision in `ST_ADD` shows at the ports as a latency of 1 in place of 3, or the reverse, when `done` rises. It also leaves a magnitude equal to the two's complement of the expected difference, visible in the same cycle as `done`. A stuck or skipped `ST_COMP` or `ST_INC` leaves the magnitude off by exactly one, or fully inverted, and a missed sign flip gives the wrong sign, all visible at `done`. A wrong busy-gating of `start` shows as a second `done` pulse or as operands from an ignored pulse appearing in the result, within four cycles of the stray pulse.

// File: rtl/sm_addsub_pkg.sv
package sm_addsub_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADD  = 3'd1,
        ST_COMP = 3'd2,
        ST_INC  = 3'd3,
        ST_DONE = 3'd4
    } sm_state_e;
endpackage

// File: rtl/sm_adder.sv
module sm_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout
);
    localparam int WX = W + 1;
    logic [WX-1:0] total;

    assign total = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    assign s     = total[W-1:0];
    assign cout  = total[W];
endmodule

// File: rtl/sm_addsub_ctrl.sv
module sm_addsub_ctrl
    import sm_addsub_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      cmp_path,
    input  logic      carry,
    output sm_state_e state,
    output logic      done,
    output logic      busy
);
    sm_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_ADD;
            ST_ADD:  st_d = (cmp_path && !carry) ? ST_COMP : ST_DONE;
            ST_COMP: st_d = ST_INC;
            ST_INC:  st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        state = st_q;
        done  = (st_q == ST_DONE);
        busy  = (st_q != ST_IDLE);
    end

    // R6: done lasts a single cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: busy covers the done cycle
    assert_busy_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    // R4: the invert step is always followed by the increment step
    assert_comp_then_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COMP) |=> (st_q == ST_INC));
endmodule

// File: rtl/sm_addsub_dp.sv
module sm_addsub_dp
    import sm_addsub_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sm_state_e    state,
    input  logic         start,
    input  logic         op_sub,
    input  logic         a_sign,
    input  logic [N-1:0] a_mag,
    input  logic         b_sign,
    input  logic [N-1:0] b_mag,
    input  logic         done,
    output logic         cmp_path,
    output logic         carry,
    output logic         res_sign,
    output logic [N-1:0] res_mag,
    output logic         ovf
);
    logic [N-1:0] a_q, b_q, add_y, add_s;
    logic         as_q, cmp_q, ovf_q, add_cin;

    // Single shared adder: operand B (true or inverted) or zero for increment
    always_comb begin
        if (state == ST_INC) begin
            add_y   = '0;
            add_cin = 1'b1;
        end else begin
            add_y   = cmp_q ? ~b_q : b_q;
            add_cin = cmp_q;
        end
    end

    sm_adder #(.W(N)) u_adder (
        .x    (a_q),
        .y    (add_y),
        .cin  (add_cin),
        .s    (add_s),
        .cout (carry)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            as_q  <= 1'b0;
            cmp_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    a_q   <= a_mag;
                    b_q   <= b_mag;
                    as_q  <= a_sign;
                    cmp_q <= a_sign ^ b_sign ^ op_sub;
                    ovf_q <= 1'b0;
                end
                ST_ADD: begin
                    a_q   <= add_s;
                    ovf_q <= cmp_q ? 1'b0 : carry;
                    if (cmp_q && carry && (add_s == '0)) as_q <= 1'b0;
                end
                ST_COMP: a_q <= ~a_q;
                ST_INC: begin
                    a_q  <= add_s;
                    as_q <= ~as_q;
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign cmp_path = cmp_q;
    assign res_sign = as_q;
    assign res_mag  = a_q;
    assign ovf      = ovf_q;

    // R3/R4: overflow never raised on the complement-add path
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMP || state == ST_INC) |-> !ovf_q);
    // R5: no negative zero after the complement-add path
    assert_no_neg_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmp_q && a_q == '0) |-> !as_q);
    // R2: sign is kept through the true-add step
    assert_trueadd_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADD && !cmp_q) |=> (as_q == $past(as_q)));
    // R7: result holds across the done cycle
    assert_hold_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(a_q) && $stable(as_q) && $stable(ovf_q)));
endmodule

// File: rtl/sm_addsub_unit.sv
module sm_addsub_unit
    import sm_addsub_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         op_sub,
    input  logic         a_sign,
    input  logic [N-1:0] a_mag,
    input  logic         b_sign,
    input  logic [N-1:0] b_mag,
    output logic         res_sign,
    output logic [N-1:0] res_mag,
    output logic         ovf,
    output logic         done,
    output logic         busy
);
    sm_state_e state;
    logic      cmp_path, carry;

    sm_addsub_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmp_path (cmp_path),
        .carry    (carry),
        .state    (state),
        .done     (done),
        .busy     (busy)
    );

    sm_addsub_dp #(.N(N)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .start    (start),
        .op_sub   (op_sub),
        .a_sign   (a_sign),
        .a_mag    (a_mag),
        .b_sign   (b_sign),
        .b_mag    (b_mag),
        .done     (done),
        .cmp_path (cmp_path),
        .carry    (carry),
        .res_sign (res_sign),
        .res_mag  (res_mag),
        .ovf      (ovf)
    );

    // R1: idle unit reports neither busy nor done
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !done);
endmodule

// File: tb/tb_sm_addsub_unit.sv
module tb_sm_addsub_unit;
    localparam int N   = 8;
    localparam int MAX = (1 << N) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0, op_sub = 1'b0, a_sign = 1'b0, b_sign = 1'b0;
    logic [N-1:0] a_mag = '0, b_mag = '0;
    logic         res_sign, ovf, done, busy;
    logic [N-1:0] res_mag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sm_addsub_unit #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
        .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
        .res_sign(res_sign), .res_mag(res_mag), .ovf(ovf),
        .done(done), .busy(busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drives one operation, checks latency, busy, result and the single done cycle
    task automatic run_op(input bit as, input int am, input bit bs, input int bm, input bit sub);
        int x, y, z, mag, emag, elat, n;
        bit esign, eovf, cmp;
        string req;
        x = as ? -am : am;
        y = (bs ^ sub) ? -bm : bm;
        z = x + y;
        mag = (z < 0) ? -z : z;
        cmp = as ^ bs ^ sub;
        if (!cmp) begin
            req = "R2"; esign = as; emag = mag & MAX; eovf = (mag > MAX); elat = 1;
        end else begin
            esign = (z < 0); emag = mag; eovf = 0;
            elat = (am < bm) ? 3 : 1;
            req = (am < bm) ? "R4" : ((mag == 0) ? "R5" : "R3");
        end
        @(negedge clk);
        a_sign = as; a_mag = am[N-1:0]; b_sign = bs; b_mag = bm[N-1:0];
        op_sub = sub; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 10) begin
            chk("R8", "busy while running", busy, 1);
            @(negedge clk);
            n++;
        end
        chk("R6", "latency", n, elat);
        chk("R8", "busy at done", busy, 1);
        chk(req, "sign", res_sign, esign);
        chk(req, "magnitude", res_mag, emag);
        chk(req, "overflow", ovf, eovf);
        @(negedge clk);
        chk("R6", "done one cycle", done, 0);
        chk("R8", "busy after done", busy, 0);
    endtask

    task automatic test_reset();
        chk("R1", "res_sign", res_sign, 0);
        chk("R1", "res_mag", res_mag, 0);
        chk("R1", "ovf", ovf, 0);
        chk("R1", "done", done, 0);
        chk("R1", "busy", busy, 0);
    endtask

    task automatic test_directed();
        run_op(0, 20, 0, 30, 0);        // R2 plain add
        run_op(1, 200, 1, 100, 0);      // R2 overflow, negative
        run_op(0, MAX, 1, MAX, 1);      // R2 max magnitude overflow via subtract
        run_op(0, 90, 0, 40, 1);        // R3
        run_op(1, 90, 0, 40, 0);        // R3 negative
        run_op(0, 40, 0, 90, 1);        // R4
        run_op(1, 0, 0, MAX, 0);        // R4 max magnitude
        run_op(1, 77, 1, 77, 1);        // R5 equal magnitudes
        run_op(1, MAX, 0, MAX, 0);      // R5 max magnitude
        run_op(0, 0, 0, 0, 1);          // R5 zero minus zero
    endtask

    task automatic test_busy_ignore();
        int n;
        @(negedge clk);
        a_sign = 0; a_mag = 8'd10; b_sign = 0; b_mag = 8'd50; op_sub = 1; start = 1;
        @(negedge clk);
        a_sign = 1; a_mag = 8'd99; b_sign = 1; b_mag = 8'd1; op_sub = 0; // stray start, R7
        @(negedge clk);
        @(negedge clk);
        start = 0;
        n = 0;
        while (!done && n < 10) begin @(negedge clk); n++; end
        chk("R7", "done seen", done, 1);
        chk("R7", "sign of accepted op", res_sign, 1);
        chk("R7", "magnitude of accepted op", res_mag, 40);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R7", "no extra done", done, 0);
            chk("R7", "held magnitude", res_mag, 40);
        end
    endtask

    task automatic test_random();
        for (int i = 0; i < 300; i++)
            run_op($urandom_range(1), $urandom_range(MAX), $urandom_range(1),
                   $urandom_range(MAX), $urandom_range(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_directed();
        test_busy_ignore();
        test_random();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule